// File: doc/BRIEF.md
# Backdoor Key Verifier

This unit carries out the command that checks a user-supplied backdoor key against the comparison key kept in non-volatile configuration storage. When the key matches, the unit releases device security. The command arrives as a twelve-byte command image plus a launch strobe. Slot 0 holds the command code. Slots 1 to 3 are ignored. Slots 4 to 11 carry the eight candidate key bytes. The stored key is supplied on a parallel bus, which stands in for the flash read path.

The unit compares the candidate key only when three conditions hold: the command code is the verify code, the mode/security permit is high, and the two-bit key-enable field selects backdoor access. The byte order is not straight. Inside each four-byte half of the key, the candidate bytes are matched against the stored bytes in reverse order.

A failed comparison locks the unit out of further attempts until reset. A stored key made of all-zero or all-0xFF bytes never matches. The result appears one clock after the launch, together with a single-cycle done pulse.

Top module: `secure_key_verifier`

## Requirements
- R1: A synchronous active-high reset clears `unsecure_o`, `acc_err_o`, `done_o` and the internal lockout.
- R2: A launch whose slot 0 (bits [7:0] of `cmd_i`) is not 0x45 produces no done pulse and leaves `acc_err_o` and `unsecure_o` unchanged.
- R3: A launch with slot 0 equal to 0x45 sampled on a clock edge raises `done_o` for exactly the following cycle.
- R4: A match requires the following pairings. Slot s is `cmd_i[8s+7:8s]` and stored offset o is `stored_key_i[8o+7:8o]`. Slots 4, 5, 6 and 7 must equal stored offsets 3, 2, 1 and 0. Slots 8, 9, 10 and 11 must equal offsets 7, 6, 5 and 4. When all eight bytes match with the permit high and the enable at 2'b10, the unit sets `unsecure_o` and clears `acc_err_o`.
- R5: A difference in any single key byte sets `acc_err_o` and does not set `unsecure_o`.
- R6: A verify launch with `access_ok_i` low sets `acc_err_o`, leaves `unsecure_o` unchanged and does not lock the unit out.
- R7: A verify launch with `key_en_i` other than 2'b10 sets `acc_err_o`, leaves `unsecure_o` unchanged and does not lock the unit out.
- R8: After a mismatch, every later verify launch sets `acc_err_o` and never sets `unsecure_o` until reset, even when the key is correct.
- R9: A stored key of all 0x00 bytes or all 0xFF bytes never matches. Such a launch sets `acc_err_o` and locks the unit out.
- R10: The contents of slots 1 to 3 have no effect on the result.
- R11: `unsecure_o` stays set until reset. `acc_err_o` reflects the most recent verify launch and is cleared by a successful one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_i | input | 1 | Command launch strobe, one cycle per command |
| cmd_i | input | CMD_SLOTS*8 | Command image; slot s is at bits [8s+7:8s] |
| stored_key_i | input | KEY_BYTES*8 | Stored comparison key; offset o is at bits [8o+7:8o] |
| access_ok_i | input | 1 | Mode and security conditions permit the command |
| key_en_i | input | 2 | Backdoor key-enable field; 2'b10 enables |
| unsecure_o | output | 1 | Security released |
| acc_err_o | output | 1 | Access error of the latest verify command |
| done_o | output | 1 | One-cycle command-complete pulse |

## Verification
The bench builds the unit with its default parameters: twelve command slots, eight key bytes in two halves of four, code 0x45 and enable value 2'b10. These values bring the reversed pairing in both halves within reach. Each of the eight byte lanes is corrupted in turn, and a key presented in straight order must fail. With the same parameters the bench also runs the lockout that follows each mismatch, the rejection of degenerate all-0x00 and all-0xFF keys, and the sticky release of security.

// File: rtl/svk_pkg.sv
package svk_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OUT_NONE    = 2'd0,
    OUT_REJECT  = 2'd1,
    OUT_LOCKOUT = 2'd2,
    OUT_GRANT   = 2'd3
  } verify_outcome_e;
endpackage

// File: rtl/key_lane_cmp.sv
module key_lane_cmp
  import svk_pkg::*;
#(
  parameter int KEY_BYTES  = 8,
  parameter int HALF_BYTES = 4
) (
  input  logic [KEY_BYTES*BYTE_W-1:0] user_key,
  input  logic [KEY_BYTES*BYTE_W-1:0] stored_key,
  output logic                        all_eq
);
  logic [KEY_BYTES-1:0] lane_eq;

  // candidate byte i pairs with the mirrored byte of its own half
  for (genvar i = 0; i < KEY_BYTES; i++) begin : g_lane
    localparam int GRP = i / HALF_BYTES;
    localparam int POS = i % HALF_BYTES;
    localparam int OFS = GRP * HALF_BYTES + (HALF_BYTES - 1 - POS);
    assign lane_eq[i] = (user_key[i*BYTE_W +: BYTE_W] == stored_key[OFS*BYTE_W +: BYTE_W]);
  end

  assign all_eq = &lane_eq;
endmodule

// File: rtl/key_validity.sv
module key_validity
  import svk_pkg::*;
#(
  parameter int KEY_BYTES = 8
) (
  input  logic [KEY_BYTES*BYTE_W-1:0] stored_key,
  output logic                        key_valid
);
  logic all_zero;
  logic all_ones;

  assign all_zero  = ~|stored_key;
  assign all_ones  = &stored_key;
  assign key_valid = !(all_zero || all_ones);
endmodule

// File: rtl/verify_ctrl.sv
module verify_ctrl
  import svk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic launch_i,
  input  logic code_hit_i,
  input  logic permit_i,
  input  logic en_ok_i,
  input  logic keys_equal_i,
  input  logic key_valid_i,
  output logic done_o,
  output logic err_o,
  output logic unsec_o
);
  verify_outcome_e outcome;
  logic            locked_q;

  always_comb begin
    outcome = OUT_NONE;
    if (launch_i && code_hit_i) begin
      if (!permit_i || !en_ok_i || locked_q) begin
        outcome = OUT_REJECT;
      end else if (!key_valid_i || !keys_equal_i) begin
        outcome = OUT_LOCKOUT;
      end else begin
        outcome = OUT_GRANT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      unsec_o  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      done_o <= (outcome != OUT_NONE);
      case (outcome)
        OUT_REJECT: begin
          err_o <= 1'b1;
        end
        OUT_LOCKOUT: begin
          err_o    <= 1'b1;
          locked_q <= 1'b1;
        end
        OUT_GRANT: begin
          err_o   <= 1'b0;
          unsec_o <= 1'b1;
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/secure_key_verifier.sv
module secure_key_verifier
  import svk_pkg::*;
#(
  parameter int         CMD_SLOTS  = 12,
  parameter int         KEY_BYTES  = 8,
  parameter int         HALF_BYTES = 4,
  parameter int         KEY_SLOT0  = 4,
  parameter logic [7:0] CMD_CODE   = 8'h45,
  parameter logic [1:0] EN_CODE    = 2'b10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        launch_i,
  input  logic [CMD_SLOTS*BYTE_W-1:0] cmd_i,
  input  logic [KEY_BYTES*BYTE_W-1:0] stored_key_i,
  input  logic                        access_ok_i,
  input  logic [1:0]                  key_en_i,
  output logic                        unsecure_o,
  output logic                        acc_err_o,
  output logic                        done_o
);
  localparam int KEY_W = KEY_BYTES * BYTE_W;

  logic             code_hit;
  logic             en_ok;
  logic             keys_equal;
  logic             key_valid;
  logic [KEY_W-1:0] user_key;
  logic             unused_slots;

  assign code_hit     = (cmd_i[BYTE_W-1:0] == CMD_CODE);
  assign en_ok        = (key_en_i == EN_CODE);
  assign user_key     = cmd_i[KEY_SLOT0*BYTE_W +: KEY_W];
  assign unused_slots = ^cmd_i[KEY_SLOT0*BYTE_W-1:BYTE_W];

  key_lane_cmp #(
    .KEY_BYTES (KEY_BYTES),
    .HALF_BYTES(HALF_BYTES)
  ) u_cmp (
    .user_key  (user_key),
    .stored_key(stored_key_i),
    .all_eq    (keys_equal)
  );

  key_validity #(
    .KEY_BYTES(KEY_BYTES)
  ) u_valid (
    .stored_key(stored_key_i),
    .key_valid (key_valid)
  );

  verify_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .launch_i    (launch_i),
    .code_hit_i  (code_hit),
    .permit_i    (access_ok_i),
    .en_ok_i     (en_ok),
    .keys_equal_i(keys_equal),
    .key_valid_i (key_valid),
    .done_o      (done_o),
    .err_o       (acc_err_o),
    .unsec_o     (unsecure_o)
  );
endmodule

// File: rtl/skv_checker.sv
module skv_checker
  import svk_pkg::*;
#(
  parameter int         CMD_SLOTS = 12,
  parameter int         KEY_BYTES = 8,
  parameter logic [7:0] CMD_CODE  = 8'h45,
  parameter logic [1:0] EN_CODE   = 2'b10
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        launch_i,
  input logic [CMD_SLOTS*BYTE_W-1:0] cmd_i,
  input logic [KEY_BYTES*BYTE_W-1:0] stored_key_i,
  input logic                        access_ok_i,
  input logic [1:0]                  key_en_i,
  input logic                        unsecure_o,
  input logic                        acc_err_o,
  input logic                        done_o
);
  logic go;
  assign go = launch_i && (cmd_i[7:0] == CMD_CODE);

  // R3
  done_follows_launch_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> done_o);

  // R2
  no_done_without_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> !done_o);

  // R2
  err_holds_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(acc_err_o));

  // R6
  permit_block_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !access_ok_i) |=> (acc_err_o && $stable(unsecure_o)));

  // R7
  keyen_block_chk: assert property (@(posedge clk) disable iff (rst)
    (go && key_en_i != EN_CODE) |=> (acc_err_o && $stable(unsecure_o)));

  // R9
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (go && (stored_key_i == '0 || stored_key_i == '1)) |=> (acc_err_o && $stable(unsecure_o)));

  // R11
  unsec_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unsecure_o |=> unsecure_o);

  // R4
  grant_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unsecure_o) |-> (done_o && !acc_err_o));
endmodule

bind secure_key_verifier skv_checker #(
  .CMD_SLOTS(CMD_SLOTS),
  .KEY_BYTES(KEY_BYTES),
  .CMD_CODE (CMD_CODE),
  .EN_CODE  (EN_CODE)
) u_skv_chk (.*);

// File: tb/tb_secure_key_verifier.sv
`timescale 1ns/1ps
module tb_secure_key_verifier;
  localparam int CW = 96;
  localparam int KW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          launch_i = 1'b0;
  logic [CW-1:0] cmd_i = '0;
  logic [KW-1:0] stored_key_i = '0;
  logic          access_ok_i = 1'b0;
  logic [1:0]    key_en_i = 2'b00;
  logic          unsecure_o, acc_err_o, done_o;

  always #2 clk = ~clk;

  secure_key_verifier dut (
    .clk(clk), .rst(rst), .launch_i(launch_i), .cmd_i(cmd_i),
    .stored_key_i(stored_key_i), .access_ok_i(access_ok_i), .key_en_i(key_en_i),
    .unsecure_o(unsecure_o), .acc_err_o(acc_err_o), .done_o(done_o)
  );

  typedef struct {
    int    due;
    logic  done;
    logic  err;
    logic  unsec;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  logic m_err = 0, m_unsec = 0, m_locked = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual={done,err,unsec}=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: compare outputs against queued expectations when they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t it;
      it = q.pop_front();
      check({done_o, acc_err_o, unsecure_o} === {it.done, it.err, it.unsec}, it.tag,
            {done_o, acc_err_o, unsecure_o}, {it.done, it.err, it.unsec});
    end
  end

  // slots 4..7 against offsets 3..0, slots 8..11 against offsets 7..4
  function automatic logic [CW-1:0] mk_cmd(input logic [KW-1:0] key);
    logic [CW-1:0] c = '0;
    c[7:0] = 8'h45;
    for (int i = 0; i < 4; i++) begin
      c[8*(4+i) +: 8] = key[8*(3-i) +: 8];
      c[8*(8+i) +: 8] = key[8*(7-i) +: 8];
    end
    return c;
  endfunction

  function automatic bit model_match(input logic [CW-1:0] c, input logic [KW-1:0] key);
    bit ok = (key != '0) && (key != '1);
    for (int i = 0; i < 4; i++) begin
      if (c[8*(4+i) +: 8] != key[8*(3-i) +: 8]) ok = 0;
      if (c[8*(8+i) +: 8] != key[8*(7-i) +: 8]) ok = 0;
    end
    return ok;
  endfunction

  task automatic issue(input logic [7:0] code, input logic permit, input logic [1:0] en,
                       input logic [CW-1:0] body, input logic [KW-1:0] key, input string tag);
    exp_t it;
    bit   hit;
    cmd_i        = body;
    cmd_i[7:0]   = code;
    stored_key_i = key;
    access_ok_i  = permit;
    key_en_i     = en;
    launch_i     = 1'b1;
    hit = (code == 8'h45);
    if (hit) begin
      if (!permit || en != 2'b10 || m_locked) m_err = 1;
      else if (!model_match(body, key)) begin m_err = 1; m_locked = 1; end
      else begin m_err = 0; m_unsec = 1; end
    end
    it.due = cyc + 1; it.done = hit; it.err = m_err; it.unsec = m_unsec; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    launch_i = 1'b0;
    it.due = cyc + 1; it.done = 1'b0; it.tag = {tag, " (done gone)"};
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    launch_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_err = 0; m_unsec = 0; m_locked = 0;
    check({done_o, acc_err_o, unsecure_o} === 3'b000, "R1 reset state",
          {done_o, acc_err_o, unsecure_o}, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1-all actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] k1 = 64'h8877665544332211;
    logic [CW-1:0] good, b;
    @(negedge clk);
    do_reset();

    // R2 foreign command code
    issue(8'h44, 1'b1, 2'b10, mk_cmd(k1), k1, "R2 foreign code 0x44");
    // R6 permit low, then R7 disabled enables; none lock out
    issue(8'h45, 1'b0, 2'b10, mk_cmd(k1), k1, "R6 permit low");
    issue(8'h45, 1'b1, 2'b11, mk_cmd(k1), k1, "R7 enable 2'b11");
    issue(8'h45, 1'b1, 2'b01, mk_cmd(k1), k1, "R7 enable 2'b01");
    issue(8'h45, 1'b1, 2'b00, mk_cmd(k1), k1, "R7 enable 2'b00");
    // R4 R10 good key with noise in slots 1..3
    good = mk_cmd(k1);
    good[31:8] = 24'hA5C3F0;
    issue(8'h45, 1'b1, 2'b10, good, k1, "R4 R10 correct key grants");
    issue(8'h46, 1'b1, 2'b10, good, k1, "R2 foreign code after grant");
    // R11 sticky unsecure, error updates then clears
    issue(8'h45, 1'b0, 2'b10, good, k1, "R11 error while unsecure");
    issue(8'h45, 1'b1, 2'b10, good, k1, "R11 success clears error");

    // R5 R8 corrupt each lane, then the correct key is refused
    for (int i = 0; i < 8; i++) begin
      do_reset();
      b = mk_cmd(k1);
      b[8*(4+i) +: 8] = b[8*(4+i) +: 8] ^ 8'h5A;
      issue(8'h45, 1'b1, 2'b10, b, k1, $sformatf("R5 lane %0d mismatch", i));
      issue(8'h45, 1'b1, 2'b10, mk_cmd(k1), k1, $sformatf("R8 lockout after lane %0d", i));
    end

    // R4 straight byte order must fail
    do_reset();
    b = '0;
    b[7:0] = 8'h45;
    b[8*4 +: 64] = k1;
    issue(8'h45, 1'b1, 2'b10, b, k1, "R4 unswapped order rejected");

    // R9 degenerate keys
    do_reset();
    issue(8'h45, 1'b1, 2'b10, mk_cmd('0), '0, "R9 all-zero key");
    issue(8'h45, 1'b1, 2'b10, mk_cmd(k1), k1, "R9 R8 locked after zero key");
    do_reset();
    issue(8'h45, 1'b1, 2'b10, mk_cmd('1), '1, "R9 all-ones key");

    // R6 R7 no lockout: refused then granted
    do_reset();
    issue(8'h45, 1'b0, 2'b10, mk_cmd(k1), k1, "R6 refused no lock");
    issue(8'h45, 1'b1, 2'b01, mk_cmd(k1), k1, "R7 refused no lock");
    b = mk_cmd(k1);
    b[31:8] = 24'h0F1E2D;
    issue(8'h45, 1'b1, 2'b10, b, k1, "R6 R7 R10 grant after refusals");

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule